// File: doc/BRIEF.md
# Master Veto Aggregator and Trigger Distributor

This block is the central unit of a dead-time supervisor for a data-acquisition system. It receives single-cycle trigger pulses from the trigger logic and sends each accepted trigger to every slave port at the same time. It also sends a synchronization request, one clock after a trigger, to start an event-number alignment cycle. That request is produced either on a host command or automatically after a programmable number of accepted triggers.

Each slave port reports one flow-control line, which is the slave's own OR of its busy and error conditions. A per-slot enable mask selects which slaves take part. The block merges the enabled lines into one registered veto and returns it to the trigger logic. While the veto is high, incoming triggers are dropped and counted rather than forwarded. The duty cycle of the veto is therefore the total dead time of the system.

Over fixed windows of clock cycles, the block counts four quantities: accepted triggers, dropped triggers, veto-high cycles and veto rising edges. At the end of each window it publishes the four counts with a one-cycle strobe, so that an external memory bank can log them as a stripchart.

Top module: `tsm_master`

## Requirements
- R1: `veto` equals the OR of `slave_busy & slave_en` as sampled on the previous clock edge. A busy line whose enable bit is 0 has no effect on `veto`.
- R2: After a synchronous reset (`rst_n` low at a clock edge), `veto`, `trig_out`, `sync_out` and `meas_valid` are all 0. All four measurement counts are 0.
- R3: A trigger is accepted when `trig_in` is 1 while `veto` is 0. On the clock edge after it is accepted, every bit of `trig_out` is 1 for exactly that one cycle. In every other cycle `trig_out` is all zeros.
- R4: A trigger seen while `veto` is 1 is not forwarded, and `trig_out` stays all zeros. Each such trigger adds one to the dropped-trigger count of the current window.
- R5: A pulse on `sync_cmd` requests a sync. The request attaches to the next accepted trigger, or to a trigger accepted in the same cycle, and it stays pending through any dropped triggers. All bits of `sync_out` then go high for one cycle, exactly one cycle after the matching `trig_out` pulse.
- R6: When `sync_every` is N, with N non-zero, a sync also goes out with every N-th accepted trigger. Triggers are counted from the last issued sync of either kind, and the count wraps at the width of `sync_every`. N = 0 turns off the automatic sync.
- R7: `meas_valid` pulses for one cycle after every WIN_LEN clock cycles, with the first window starting at reset release. It is 0 in every other cycle.
- R8: With each `meas_valid` pulse, `meas_dead` gives the number of cycles in the window during which `veto` was 1. `meas_toggle` gives the number of 0-to-1 transitions of `veto` in the window, where a window's first cycle counts as a transition if `veto` is 1 in it and was 0 in the cycle before.
- R9: With each `meas_valid` pulse, `meas_trig` gives the number of accepted triggers in the window. `meas_drop` gives the number of dropped triggers in the same window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | 1 | Trigger pulse from the trigger logic |
| sync_cmd | input | 1 | Host request for a sync on the next accepted trigger |
| sync_every | input | SYNC_W | Automatic sync period in accepted triggers; 0 disables it |
| slave_en | input | N_SLAVE | Slot enable mask for the veto OR |
| slave_busy | input | N_SLAVE | Combined flow-control line of each slave |
| veto | output | 1 | Global trigger inhibit (total dead time) |
| trig_out | output | N_SLAVE | Trigger fan-out to the slaves |
| sync_out | output | N_SLAVE | Sync-request fan-out to the slaves |
| meas_valid | output | 1 | One-cycle strobe marking a new set of window results |
| meas_trig | output | CNT_W | Accepted triggers in the last window |
| meas_drop | output | CNT_W | Dropped triggers in the last window |
| meas_dead | output | CNT_W | Veto-high cycles in the last window |
| meas_toggle | output | CNT_W | Veto rising edges in the last window |

## Verification
The assertions check the following on every cycle:
- the veto follows the enabled busy lines one edge later;
- a trigger that meets a high veto never reaches the fan-out;
- a sync pulse always follows a trigger pulse;
- the result strobe lasts one cycle;
- the published toggle count never exceeds the dead-time count.

The bench scenarios are the only way to show the rest:
- that the published counts match an arithmetic tally of each window;
- that a host request stays pending across dropped triggers;
- that automatic syncs fall on exactly every N-th accepted trigger for each period swept, including zero.

The bench sweeps every combination of busy and enable for a four-slave configuration.

// File: rtl/tsm_pkg.sv
// Shared definitions for the master veto and trigger distributor.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tsm_pkg;
    // Index of each per-window metric inside the event vector.
    localparam int M_ACC  = 0;   // accepted triggers
    localparam int M_DROP = 1;   // triggers dropped by veto
    localparam int M_DEAD = 2;   // cycles with veto high
    localparam int M_EDGE = 3;   // veto rising edges
    localparam int NUM_METRICS = 4;
endpackage

// File: rtl/tsm_veto_merge.sv
// Merges enabled slave flow-control lines into one registered veto and
// flags its rising edges.
// Assumes slave_busy is already synchronous to clk.
module tsm_veto_merge #(
    parameter int N_SLAVE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLAVE-1:0] slave_busy,
    input  logic [N_SLAVE-1:0] slave_en,
    output logic               veto,
    output logic               veto_rise
);
    logic veto_prev;

    // Register the masked OR and keep last cycle's veto for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            veto      <= 1'b0;
            veto_prev <= 1'b0;
        end else begin
            veto      <= |(slave_busy & slave_en);
            veto_prev <= veto;
        end
    end

    // A rising edge is a cycle with veto high after a cycle with it low.
    always_comb veto_rise = veto & ~veto_prev;

    // R1
    veto_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(slave_busy & slave_en)) |=> veto);
    // R1
    veto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(slave_busy & slave_en)) |=> !veto);
endmodule

// File: rtl/tsm_trig_fanout.sv
// Gates incoming triggers with the veto, fans accepted ones out to every
// slave, and attaches sync requests (host or every N triggers) one clock
// behind the trigger they accompany.
// Assumes trig_in is a single-cycle pulse synchronous to clk.
module tsm_trig_fanout #(
    parameter int N_SLAVE = 16,
    parameter int SYNC_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               veto,
    input  logic               sync_cmd,
    input  logic [SYNC_W-1:0]  sync_every,
    output logic               accept,
    output logic               drop,
    output logic [N_SLAVE-1:0] trig_out,
    output logic [N_SLAVE-1:0] sync_out
);
    logic [SYNC_W-1:0] tcnt;
    logic              pend;
    logic              auto_hit;
    logic              issue;
    logic              sync_stage;

    // Classify the trigger and decide whether it carries a sync.
    always_comb begin
        accept   = trig_in & ~veto;
        drop     = trig_in & veto;
        auto_hit = (sync_every != '0) && ((tcnt + SYNC_W'(1)) == sync_every);
        issue    = accept & (pend | sync_cmd | auto_hit);
    end

    // Fan out the trigger, delay the sync by one stage, track period and request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_out   <= '0;
            sync_stage <= 1'b0;
            sync_out   <= '0;
            tcnt       <= '0;
            pend       <= 1'b0;
        end else begin
            trig_out   <= {N_SLAVE{accept}};
            sync_stage <= issue;
            sync_out   <= {N_SLAVE{sync_stage}};
            if (issue) begin
                tcnt <= '0;
                pend <= 1'b0;
            end else begin
                if (accept)   tcnt <= tcnt + SYNC_W'(1);
                if (sync_cmd) pend <= 1'b1;
            end
        end
    end

    // R4
    drop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_in && veto) |=> (trig_out == '0));
    // R5
    sync_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out != '0) |-> ($past(trig_out) != '0));
    // R3
    trig_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_in |=> (trig_out == '0));
endmodule

// File: rtl/tsm_window_meas.sv
// Counts one-bit events over fixed windows of WIN_LEN cycles and publishes
// all counts together with a one-cycle valid strobe.
// Assumes WIN_LEN >= 2; results hold until the next window closes.
module tsm_window_meas #(
    parameter int WIN_LEN = 1024,
    parameter int NM      = 4,
    parameter int CNT_W   = 11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NM-1:0]             evt,
    output logic                      meas_valid,
    output logic [NM-1:0][CNT_W-1:0]  meas_cnt
);
    localparam int TW = $clog2(WIN_LEN);
    localparam logic [TW-1:0] LAST = TW'(WIN_LEN - 1);

    logic [TW-1:0] wcnt;
    logic          last;

    always_comb last = (wcnt == LAST);

    // Window timer and result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt       <= '0;
            meas_valid <= 1'b0;
        end else begin
            wcnt       <= last ? '0 : wcnt + TW'(1);
            meas_valid <= last;
        end
    end

    // One accumulator and one result register per metric.
    for (genvar i = 0; i < NM; i++) begin : g_metric
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] sum;
        always_comb sum = acc + CNT_W'(evt[i]);
        // Accumulate in-window events; publish and restart at window end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc         <= '0;
                meas_cnt[i] <= '0;
            end else if (last) begin
                acc         <= '0;
                meas_cnt[i] <= sum;
            end else begin
                acc         <= sum;
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);
endmodule

// File: rtl/tsm_master.sv
// Master unit of the dead-time supervisor: builds the global veto from the
// enabled slaves, distributes triggers and sync requests, and measures
// trigger rate, dropped triggers, dead time and veto frequency per window.
// Assumes all inputs are synchronous to clk.
module tsm_master #(
    parameter int N_SLAVE = 16,
    parameter int SYNC_W  = 8,
    parameter int WIN_LEN = 1024,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig_in,
    input  logic               sync_cmd,
    input  logic [SYNC_W-1:0]  sync_every,
    input  logic [N_SLAVE-1:0] slave_en,
    input  logic [N_SLAVE-1:0] slave_busy,
    output logic               veto,
    output logic [N_SLAVE-1:0] trig_out,
    output logic [N_SLAVE-1:0] sync_out,
    output logic               meas_valid,
    output logic [CNT_W-1:0]   meas_trig,
    output logic [CNT_W-1:0]   meas_drop,
    output logic [CNT_W-1:0]   meas_dead,
    output logic [CNT_W-1:0]   meas_toggle
);
    import tsm_pkg::*;

    logic                                 veto_rise;
    logic                                 accept;
    logic                                 drop;
    logic [NUM_METRICS-1:0]               evt;
    logic [NUM_METRICS-1:0][CNT_W-1:0]    cnt;

    tsm_veto_merge #(.N_SLAVE(N_SLAVE)) u_veto (
        .clk(clk), .rst_n(rst_n),
        .slave_busy(slave_busy), .slave_en(slave_en),
        .veto(veto), .veto_rise(veto_rise)
    );

    tsm_trig_fanout #(.N_SLAVE(N_SLAVE), .SYNC_W(SYNC_W)) u_fan (
        .clk(clk), .rst_n(rst_n),
        .trig_in(trig_in), .veto(veto),
        .sync_cmd(sync_cmd), .sync_every(sync_every),
        .accept(accept), .drop(drop),
        .trig_out(trig_out), .sync_out(sync_out)
    );

    // Gather the per-cycle events for the window counters.
    always_comb begin
        evt         = '0;
        evt[M_ACC]  = accept;
        evt[M_DROP] = drop;
        evt[M_DEAD] = veto;
        evt[M_EDGE] = veto_rise;
    end

    tsm_window_meas #(.WIN_LEN(WIN_LEN), .NM(NUM_METRICS), .CNT_W(CNT_W)) u_meas (
        .clk(clk), .rst_n(rst_n),
        .evt(evt), .meas_valid(meas_valid), .meas_cnt(cnt)
    );

    // Split the result vector onto named ports.
    always_comb begin
        meas_trig   = cnt[M_ACC];
        meas_drop   = cnt[M_DROP];
        meas_dead   = cnt[M_DEAD];
        meas_toggle = cnt[M_EDGE];
    end

    // R8
    toggle_le_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (meas_toggle <= meas_dead));
    // R8
    dead_le_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |-> (32'(meas_dead) <= WIN_LEN));
endmodule

// File: tb/sim_tsm_master.sv
module sim_tsm_master;
    localparam int NS  = 4;
    localparam int SW  = 4;
    localparam int WIN = 32;
    localparam int CW  = $clog2(WIN + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig_in, sync_cmd;
    logic [SW-1:0] sync_every;
    logic [NS-1:0] slave_en, slave_busy;
    logic          veto, meas_valid;
    logic [NS-1:0] trig_out, sync_out;
    logic [CW-1:0] meas_trig, meas_drop, meas_dead, meas_toggle;

    tsm_master #(.N_SLAVE(NS), .SYNC_W(SW), .WIN_LEN(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .sync_cmd(sync_cmd),
        .sync_every(sync_every), .slave_en(slave_en), .slave_busy(slave_busy),
        .veto(veto), .trig_out(trig_out), .sync_out(sync_out),
        .meas_valid(meas_valid), .meas_trig(meas_trig), .meas_drop(meas_drop),
        .meas_dead(meas_dead), .meas_toggle(meas_toggle)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit started = 0;
    bit rst_seen = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model state (bench-side arithmetic from the requirements)
    int nidx = 0;
    int a_acc = 0, a_drop = 0, a_dead = 0, a_edge = 0;
    bit prev_v = 0, e_veto = 0, e_trig = 0, e_s1 = 0, e_s2 = 0, pend = 0;
    logic [SW-1:0] scnt = '0;

    always @(posedge clk) begin
        started  <= 1'b1;
        rst_seen <= rst_n;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            if (!rst_seen) begin
                // R2 reset state
                chk(veto == 1'b0, "R2 veto", int'(veto), 0);
                chk(trig_out == '0, "R2 trig_out", int'(trig_out), 0);
                chk(sync_out == '0, "R2 sync_out", int'(sync_out), 0);
                chk(meas_valid == 1'b0 && meas_dead == '0, "R2 meas", int'(meas_dead), 0);
                nidx = 0; a_acc = 0; a_drop = 0; a_dead = 0; a_edge = 0;
                prev_v = 0; e_veto = 0; e_trig = 0; e_s1 = 0; e_s2 = 0; pend = 0; scnt = '0;
            end else begin
                nidx++;
                chk(veto == e_veto, "R1 veto", int'(veto), int'(e_veto));
                chk(trig_out == (e_trig ? {NS{1'b1}} : '0), "R3 R4 trig_out",
                    int'(trig_out), e_trig ? 15 : 0);
                chk(sync_out == (e_s2 ? {NS{1'b1}} : '0), "R5 R6 sync_out",
                    int'(sync_out), e_s2 ? 15 : 0);
                if (nidx % WIN == 0) begin
                    chk(meas_valid == 1'b1, "R7 valid", int'(meas_valid), 1);
                    chk(int'(meas_trig) == a_acc, "R9 meas_trig", int'(meas_trig), a_acc);
                    chk(int'(meas_drop) == a_drop, "R4 R9 meas_drop", int'(meas_drop), a_drop);
                    chk(int'(meas_dead) == a_dead, "R8 meas_dead", int'(meas_dead), a_dead);
                    chk(int'(meas_toggle) == a_edge, "R8 meas_toggle", int'(meas_toggle), a_edge);
                    a_acc = 0; a_drop = 0; a_dead = 0; a_edge = 0;
                end else begin
                    chk(meas_valid == 1'b0, "R7 no valid", int'(meas_valid), 0);
                end
            end
            // Sample inputs for the coming edge.
            begin
                bit acc_now, issue, pnow, ahit;
                acc_now = trig_in && !veto;
                a_acc  += int'(acc_now);
                a_drop += int'(trig_in && veto);
                a_dead += int'(veto);
                a_edge += int'(veto && !prev_v);
                prev_v  = veto;
                pnow    = pend || sync_cmd;
                ahit    = (sync_every != '0) && ((scnt + SW'(1)) == sync_every);
                issue   = acc_now && (pnow || ahit);
                if (issue) begin scnt = '0; pend = 0; end
                else begin
                    if (acc_now) scnt = scnt + SW'(1);
                    pend = pnow;
                end
                e_s2   = e_s1;
                e_s1   = issue;
                e_trig = acc_now;
                e_veto = |(slave_busy & slave_en);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    task automatic adv();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        rst_n = 0; trig_in = 0; sync_cmd = 0; sync_every = '0;
        slave_en = '0; slave_busy = '0;
        repeat (3) step();
        rst_n = 1;
        // R1 sweep of all busy and enable patterns under random triggers
        sync_every = 4'd3;
        for (int e = 0; e < 16; e++) begin
            for (int b = 0; b < 16; b++) begin
                adv();
                slave_en = NS'(e); slave_busy = NS'(b);
                trig_in  = lfsr[0] | lfsr[5];
                sync_cmd = lfsr[2] & lfsr[7] & lfsr[9];
                step();
            end
        end
        // R6 sweep of automatic sync periods with veto off
        slave_busy = '0; slave_en = '1; sync_cmd = 0;
        for (int n = 0; n < 6; n++) begin
            sync_every = SW'(n);
            for (int k = 0; k < 40; k++) begin
                adv();
                trig_in = lfsr[1] | lfsr[4];
                step();
            end
        end
        // R5 host request held across dropped triggers
        sync_every = '0; trig_in = 0;
        slave_busy = 4'b0100; step();
        sync_cmd = 1; trig_in = 1; step();
        sync_cmd = 0;
        repeat (6) step();
        slave_busy = '0; trig_in = 0; step();
        trig_in = 1; step();
        trig_in = 0; repeat (4) step();
        // R2 reset in the middle of activity
        rst_n = 0; slave_busy = 4'b1111; trig_in = 1; repeat (2) step();
        rst_n = 1; slave_busy = '0;
        // R8 R9 toggling veto patterns through full windows
        for (int k = 0; k < 3 * WIN; k++) begin
            adv();
            slave_busy = {3'b000, lfsr[3]};
            trig_in = lfsr[6];
            step();
        end
        trig_in = 0; slave_busy = '0;
        repeat (WIN + 2) step();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule